// File: doc/BRIEF.md
# Dual-Line Serial Flash Sequential Fetch Engine

This block answers single-byte read requests from a processor bus by fetching the bytes from an external serial flash. It uses the dual-output fast read command. A request that does not continue an open burst sends a command header, which is a programmable opcode, a 24-bit address and eight dummy clocks. After the header, each data byte arrives over two data lines in four serial clocks. The primary data line drives the header. It is released from the first dummy clock onward so that the flash can return data on it.

After each byte the burst stays open with the serial clock parked low. If the next request names the previous address plus one, only four more clocks run and no new header is sent. Any other request raises chip enable for one serial clock and then starts a fresh header at the new address. The serial clock runs at half the system clock and uses mode 0 timing: it idles low, outputs change on the falling edge and inputs are sampled on the rising edge.

Top module: `dspi_fetch`

## Requirements
- R1: After reset, chip enable is high, the serial clock is low, ready is low and the primary line's output enable is low.
- R2: A new burst sends 32 bits on the primary line, MSB first: the opcode input (8 bits), then a 24-bit address whose bits 23..17 are zero and whose bits 16..0 are the requested processor address.
- R3: The primary line is driven (output enable high) for all 32 header clocks and released (output enable low) from the first of the eight dummy clocks through every data clock.
- R4: Each data byte takes four serial clocks. The primary line carries bits 7,5,3,1 and the secondary line carries bits 6,4,2,0, with the pair for bits 7/6 first. Each pair is sampled at a rising edge.
- R5: Ready is a single-cycle pulse that presents the byte. For a request made when no burst is open, it rises 88 system cycles after the cycle in which the request was sampled.
- R6: A request for exactly the previous address plus one keeps chip enable low, runs exactly four more serial clocks with no header, and raises ready 8 cycles after the request.
- R7: Any other request raises chip enable for exactly 2 system cycles (one serial clock) and then sends a new header. Ready rises 90 cycles after the request.
- R8: The serial clock is low whenever chip enable is high or the burst is parked, and the primary output holds its value while the serial clock is high.
- R9: Sequential detection uses the full 17-bit address plus a carry bit, so address 0x00000 after 0x1FFFF counts as non-sequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opcode | input | 8 | Read opcode sent in the header (normally 0x3B) |
| cpu_addr | input | 17 | Processor byte address, sampled with cpu_rd |
| cpu_rd | input | 1 | One-cycle read request; only issued while no fetch is in flight |
| cpu_data | output | 8 | Fetched byte, valid with cpu_rdy |
| cpu_rdy | output | 1 | One-cycle pulse: cpu_data is valid |
| cs_n | output | 1 | Flash chip enable, active low |
| sck | output | 1 | Serial clock, mode 0 |
| io0_o | output | 1 | Primary data line output value |
| io0_oe | output | 1 | Primary data line output enable |
| io0_i | input | 1 | Primary data line input (bits 7,5,3,1) |
| io1_i | input | 1 | Secondary data line input (bits 6,4,2,0) |

## Verification
Measured from the clock edge that samples the request, ready is due after 88 cycles for a fresh burst, 8 cycles for a sequential continuation and 90 cycles after a broken burst. The bench counts whole cycles from the request to the ready pulse and requires those exact numbers. A flash model in the bench counts header bits on rising serial edges, drives each data pair on the falling edge before it is needed, and records the output enable at every rising edge. Chip-enable-high time is counted in system cycles at clock edges, so the one-serial-clock gap is checked as exactly two cycles.

// File: rtl/dspi_pkg.sv
package dspi_pkg;
   localparam int OP_W     = 8;
   localparam int FLASH_AW = 24;
   localparam int BYTE_W   = 8;
   localparam int LANES    = 2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_GAP,
      ST_CMD,
      ST_DUMMY,
      ST_DATA,
      ST_OPEN
   } fetch_st_e;
endpackage

// File: rtl/dspi_seq_det.sv
module dspi_seq_det #(
   parameter int AW = 17
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          capture,
   input  logic [AW-1:0] cap_addr,
   input  logic [AW-1:0] req_addr,
   output logic          seq_hit
);
   logic [AW-1:0] last_q;
   logic [AW:0]   next_w;

   // carry bit kept so the top address does not wrap onto zero (R9)
   assign next_w  = {1'b0, last_q} + (AW+1)'(1);
   assign seq_hit = (next_w == {1'b0, req_addr});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       last_q <= '0;
      else if (capture) last_q <= cap_addr;
   end

   // r9: a top-of-range address never matches a zero request
   a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (last_q == {AW{1'b1}}) |-> !(seq_hit && req_addr == '0));
endmodule

// File: rtl/dspi_shift.sv
module dspi_shift #(
   parameter int AW  = 17,
   parameter int FAW = 24,
   parameter int OPW = 8,
   parameter int BW  = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [OPW-1:0] opcode,
   input  logic [AW-1:0] addr,
   input  logic          shift_en,
   input  logic          samp_en,
   input  logic          io0_i,
   input  logic          io1_i,
   output logic          tx_bit,
   output logic [BW-1:0] rx_byte
);
   localparam int HW = OPW + FAW;

   logic [HW-1:0]  hdr_q;
   logic [FAW-1:0] faddr;

   generate
      if (AW > FAW) begin : g_bad_width
         $error("dspi_shift: AW wider than flash address");
      end else if (AW == FAW) begin : g_direct
         assign faddr = addr;
      end else begin : g_pad
         assign faddr = {{(FAW-AW){1'b0}}, addr};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hdr_q <= '0;
      else if (load)     hdr_q <= {opcode, faddr};
      else if (shift_en) hdr_q <= {hdr_q[HW-2:0], 1'b0};
   end

   // primary line holds the higher bit of each pair (R4)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rx_byte <= '0;
      else if (samp_en) rx_byte <= {rx_byte[BW-3:0], io0_i, io1_i};
   end

   assign tx_bit = hdr_q[HW-1];
endmodule

// File: rtl/dspi_fetch.sv
module dspi_fetch
   import dspi_pkg::*;
#(
   parameter int ADDR_W     = 17,
   parameter int DUMMY_CLKS = 8,
   parameter int GAP_CYC    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OP_W-1:0]   opcode,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_rd,
   output logic [BYTE_W-1:0] cpu_data,
   output logic              cpu_rdy,
   output logic              cs_n,
   output logic              sck,
   output logic              io0_o,
   output logic              io0_oe,
   input  logic              io0_i,
   input  logic              io1_i
);
   localparam int HDR_BITS = OP_W + FLASH_AW;
   localparam int PAIRS    = BYTE_W / LANES;
   localparam int MAXC     = (HDR_BITS > DUMMY_CLKS) ? HDR_BITS : DUMMY_CLKS;
   localparam int CNT_W    = $clog2(MAXC + 1);
   localparam int GAP_W    = $clog2(GAP_CYC + 1);

   generate
      if (ADDR_W < 1 || ADDR_W > FLASH_AW) begin : g_chk_aw
         $error("dspi_fetch: ADDR_W out of range");
      end
      if (DUMMY_CLKS < 1) begin : g_chk_dummy
         $error("dspi_fetch: DUMMY_CLKS must be positive");
      end
      if (GAP_CYC < 1) begin : g_chk_gap
         $error("dspi_fetch: GAP_CYC must be positive");
      end
   endgenerate

   fetch_st_e         st;
   logic              ph;
   logic [CNT_W-1:0]  cnt;
   logic [GAP_W-1:0]  gcnt;
   logic [ADDR_W-1:0] pend;
   logic              seq_hit;
   logic              start_new;
   logic              seq_go;
   logic [ADDR_W-1:0] start_addr;
   logic              shift_en;
   logic              samp_en;
   logic [BYTE_W-1:0] rx_byte;
   logic              tx_bit;

   assign start_new  = (st == ST_IDLE && cpu_rd) || (st == ST_GAP && gcnt == '0);
   assign seq_go     = (st == ST_OPEN) && cpu_rd && seq_hit;
   assign start_addr = (st == ST_GAP) ? pend : cpu_addr;
   assign shift_en   = (st == ST_CMD) && ph;
   assign samp_en    = (st == ST_DATA) && !ph;

   dspi_seq_det #(.AW(ADDR_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (start_new || seq_go),
      .cap_addr (start_addr),
      .req_addr (cpu_addr),
      .seq_hit  (seq_hit)
   );

   dspi_shift #(.AW(ADDR_W), .FAW(FLASH_AW), .OPW(OP_W), .BW(BYTE_W)) u_sh (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start_new),
      .opcode   (opcode),
      .addr     (start_addr),
      .shift_en (shift_en),
      .samp_en  (samp_en),
      .io0_i    (io0_i),
      .io1_i    (io1_i),
      .tx_bit   (tx_bit),
      .rx_byte  (rx_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         ph       <= 1'b0;
         cnt      <= '0;
         gcnt     <= '0;
         pend     <= '0;
         sck      <= 1'b0;
         cs_n     <= 1'b1;
         cpu_rdy  <= 1'b0;
         cpu_data <= '0;
      end else begin
         cpu_rdy <= 1'b0;
         if (start_new) begin
            st   <= ST_CMD;
            cs_n <= 1'b0;
            ph   <= 1'b0;
            cnt  <= CNT_W'(HDR_BITS);
         end else begin
            unique case (st)
               ST_IDLE: ;
               ST_OPEN: begin
                  if (cpu_rd) begin
                     pend <= cpu_addr;
                     if (seq_hit) begin
                        st  <= ST_DATA;
                        ph  <= 1'b0;
                        cnt <= CNT_W'(PAIRS);
                     end else begin
                        st   <= ST_GAP;
                        cs_n <= 1'b1;
                        gcnt <= GAP_W'(GAP_CYC - 1);
                     end
                  end
               end
               ST_GAP: gcnt <= gcnt - 1'b1;
               default: begin
                  if (!ph) begin
                     sck <= 1'b1;
                     ph  <= 1'b1;
                  end else begin
                     sck <= 1'b0;
                     ph  <= 1'b0;
                     if (cnt == CNT_W'(1)) begin
                        if (st == ST_CMD) begin
                           st  <= ST_DUMMY;
                           cnt <= CNT_W'(DUMMY_CLKS);
                        end else if (st == ST_DUMMY) begin
                           st  <= ST_DATA;
                           cnt <= CNT_W'(PAIRS);
                        end else begin
                           st       <= ST_OPEN;
                           cpu_rdy  <= 1'b1;
                           cpu_data <= rx_byte;
                        end
                     end else begin
                        cnt <= cnt - 1'b1;
                     end
                  end
               end
            endcase
         end
      end
   end

   assign io0_o  = tx_bit;
   assign io0_oe = (st == ST_CMD);

   a_r1_idle_cs: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> (cs_n && !sck && !io0_oe));
   a_r3_released: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DUMMY || st == ST_DATA) |-> !io0_oe);
   a_r5_rdy_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rdy |=> !cpu_rdy);
   a_r6_seq_keeps_cs: assert property (@(posedge clk) disable iff (!rst_n)
      seq_go |=> (st == ST_DATA && !cs_n));
   a_r7_gap_min: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |=> cs_n);
   a_r8_sck_parked: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || st == ST_OPEN) |-> !sck);
   a_r8_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
      sck |-> $stable(io0_o));
endmodule

// File: tb/sim_dspi_fetch.sv
module sim_dspi_fetch;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  opcode = 8'h3B;
   logic [16:0] cpu_addr = '0;
   logic        cpu_rd = 1'b0;
   logic [7:0]  cpu_data;
   logic        cpu_rdy;
   logic        cs_n, sck, io0_o, io0_oe;
   logic        io0_i = 1'b0;
   logic        io1_i = 1'b0;

   int checks = 0;
   int fails  = 0;

   always #(PERIOD/2) clk = ~clk;

   dspi_fetch u0 (
      .clk(clk), .rst_n(rst_n), .opcode(opcode), .cpu_addr(cpu_addr),
      .cpu_rd(cpu_rd), .cpu_data(cpu_data), .cpu_rdy(cpu_rdy), .cs_n(cs_n),
      .sck(sck), .io0_o(io0_o), .io0_oe(io0_oe), .io0_i(io0_i), .io1_i(io1_i)
   );

   function automatic logic [7:0] fbyte(input logic [23:0] a);
      return 8'((a * 24'd29) + 24'd7);
   endfunction

   // flash model
   int          fcnt = 0;
   int          oe_bad = 0;
   int          ncmd = 0;
   logic [31:0] cap = '0;
   logic [23:0] fbase = '0;

   always @(posedge sck or posedge cs_n) begin
      if (cs_n) fcnt = 0;
      else begin
         if (fcnt < 32) begin
            if (io0_oe !== 1'b1) oe_bad++;
            cap = {cap[30:0], io0_o};
            if (fcnt == 31) fbase = cap[23:0];
         end else if (io0_oe !== 1'b0) oe_bad++;
         fcnt++;
      end
   end

   always @(negedge sck) begin
      if (!cs_n && fcnt >= 40) begin
         int k;
         int p;
         logic [7:0] b;
         k = fcnt - 40;
         p = k % 4;
         b = fbyte(fbase + 24'(k / 4));
         io0_i = b[7 - 2*p];
         io1_i = b[6 - 2*p];
      end
   end

   always @(negedge cs_n) ncmd++;

   int hc = 0;
   int last_hc = 0;
   always @(posedge clk) begin
      if (rst_n) begin
         if (cs_n) hc++;
         else begin
            if (hc > 0) last_hc = hc;
            hc = 0;
         end
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_read(input logic [16:0] a, input int exp_lat, input bit newcmd,
                          input string tag);
      int n;
      int c0;
      c0 = ncmd;
      @(negedge clk);
      cpu_addr = a;
      cpu_rd = 1'b1;
      n = 0;
      while (1) begin
         @(negedge clk);
         cpu_rd = 1'b0;
         n++;
         if (cpu_rdy || n > 500) break;
      end
      check(n - 1 == exp_lat, tag, n - 1, exp_lat);
      check(cpu_data == fbyte({7'b0, a}), "R4 data", cpu_data, fbyte({7'b0, a}));
      if (newcmd) begin
         check(cap == {opcode, 7'b0, a}, "R2 header", cap, {opcode, 7'b0, a});
         check(ncmd == c0 + 1, "R7 new header", ncmd - c0, 1);
      end else begin
         check(ncmd == c0, "R6 no header", ncmd - c0, 0);
      end
      @(negedge clk);
      check(!cpu_rdy && !sck && !cs_n, "R5 R8 pulse/park", {cpu_rdy, sck, cs_n}, 0);
   endtask

   initial begin
      #(PERIOD * 200000);
      fails++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [16:0] bases [4];
      bases[0] = 17'h10000; bases[1] = 17'h0AAAA;
      bases[2] = 17'h15555; bases[3] = 17'h000FF;
      repeat (3) @(negedge clk);
      check(cs_n && !sck && !cpu_rdy && !io0_oe, "R1 reset",
            {cs_n, sck, cpu_rdy, io0_oe}, 4'b1000);
      rst_n = 1'b1;
      @(negedge clk);
      check(cs_n && !sck, "R1 after release", {cs_n, sck}, 2'b10);

      do_read(17'h00123, 88, 1, "R5 fresh latency");
      for (int i = 1; i <= 5; i++) do_read(17'h00123 + 17'(i), 8, 0, "R6 seq latency");
      do_read(17'h1FFFE, 90, 1, "R7 jump latency");
      check(last_hc == 2, "R7 cs high time", last_hc, 2);
      do_read(17'h1FFFF, 8, 0, "R6 seq latency");
      do_read(17'h00000, 90, 1, "R9 wrap not sequential");
      for (int b = 0; b < 4; b++) begin
         do_read(bases[b], 90, 1, "R7 jump latency");
         for (int j = 1; j <= 3; j++) do_read(bases[b] + 17'(j), 8, 0, "R6 seq latency");
      end
      opcode = 8'h5A;
      do_read(17'h00042, 90, 1, "R2 programmable opcode");
      do_read(17'h00041, 90, 1, "R7 backward jump");
      do_read(17'h00041, 90, 1, "R7 repeat address");
      check(last_hc == 2, "R7 cs high time", last_hc, 2);
      check(oe_bad == 0, "R3 output enable", oe_bad, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule